// File: doc/BRIEF.md
# Floppy DMA Request Sequencer

This block drives the DMA request line of a disk controller while a data-transfer command is in its execution phase. It talks to a host DMA engine through a request output and an active-low acknowledge input. It turns each acknowledged cycle into one byte strobe toward the data FIFO, either a read strobe or a write strobe. No address is decoded: the acknowledge alone selects the FIFO.

A one-bit mode setting chooses between two handshakes. In single-transfer mode the request drops once each acknowledge is seen, and it returns after the acknowledge is released. In burst mode the request stays asserted across acknowledges until the byte flagged as the last one has moved. The execution logic supplies a DMA-enable level, a transfer-pending level, the direction of the current command and the FIFO-enable setting. The host supplies the last-transfer (terminal count) flag and a verify-cycle flag along with its acknowledge. During a verify cycle the block performs a read driven only by the acknowledge. It does so only in byte mode (FIFO off) with a read command in progress.

Top module: `fdc_dma_req`

## Requirements
- R1: After reset `drq`, `rd_stb` and `wr_stb` are 0 and the mode is single-transfer (mode bit reads as 1).
- R2: `drq` is 0 in every cycle in which `dma_en` or `xfer_pend` is 0, with no delay.
- R3: In single-transfer mode (mode bit 1), `drq` rises one clock after `dma_en`, `xfer_pend` and `dack_n` are all sampled high. It falls one clock after the first clock at which `dack_n` is sampled low. It stays low while `dack_n` stays low and rises again one clock after `dack_n` is sampled high.
- R4: In burst mode (mode bit 0), `drq` stays 1 across acknowledges as long as `dma_en` and `xfer_pend` stay high and no last transfer has been flagged.
- R5: If `last_xfer` is 1 at the first clock of an acknowledge, `drq` is 0 from the next clock on, in either mode. It stays 0 until `xfer_pend` has been sampled low.
- R6: Each acknowledge is a high-to-low change of sampled `dack_n` while `dma_en` and `xfer_pend` are 1. Each one gives exactly one strobe, one clock wide, in the clock after the change: `rd_stb` when `xfer_rd` is 1 and `wr_stb` when it is 0. An acknowledge outside a transfer gives no strobe.
- R7: When `vfy_cyc` is 1 at the acknowledge, `rd_stb` is given only if `fifo_en` is 0 and `xfer_rd` is 1. No strobe is given otherwise.
- R8: A clock with `mode_we` = 1 loads `mode_bit`: 1 selects single-transfer and 0 selects burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Load strobe for the mode bit |
| mode_bit | input | 1 | New mode: 1 single-transfer, 0 burst |
| dma_en | input | 1 | DMA mode enabled by the set-up command |
| xfer_pend | input | 1 | Data-transfer command executing with bytes left |
| xfer_rd | input | 1 | Direction of the command: 1 read (FIFO to host), 0 write |
| fifo_en | input | 1 | FIFO enabled (0 means byte mode) |
| dack_n | input | 1 | Active-low DMA acknowledge from the host |
| last_xfer | input | 1 | Terminal count, valid with the acknowledge |
| vfy_cyc | input | 1 | Host DMA engine is running a verify cycle |
| drq | output | 1 | DMA request |
| rd_stb | output | 1 | One-clock strobe that pops a byte from the FIFO |
| wr_stb | output | 1 | One-clock strobe that pushes a byte into the FIFO |

## Verification
The request decision and the strobe generation fall in the same clock whenever an acknowledge arrives. In that clock the block must drop or hold `drq` according to the mode and the last-transfer flag, and must also choose between a read strobe, a write strobe and no strobe according to the direction, the verify flag and the FIFO setting. The bench sweeps every combination of mode, direction, verify, FIFO enable and last-transfer through one acknowledge each. It computes both the expected request level and the expected strobes arithmetically, and compares them in the clocks after the acknowledge, including the release of the acknowledge and the end of the transfer.

// File: rtl/fdc_dma_req.sv
module fdc_dma_req (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_we,
  input  logic mode_bit,
  input  logic dma_en,
  input  logic xfer_pend,
  input  logic xfer_rd,
  input  logic fifo_en,
  input  logic dack_n,
  input  logic last_xfer,
  input  logic vfy_cyc,
  output logic drq,
  output logic rd_stb,
  output logic wr_stb
);

  logic single_q, drq_q, done_q, dack_q;

  wire live     = dma_en & xfer_pend;
  wire ack_edge = live & dack_q & ~dack_n;
  wire rd_ok    = xfer_rd & (~vfy_cyc | ~fifo_en);
  wire wr_ok    = ~xfer_rd & ~vfy_cyc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      single_q <= 1'b1;
      drq_q    <= 1'b0;
      done_q   <= 1'b0;
      dack_q   <= 1'b1;
      rd_stb   <= 1'b0;
      wr_stb   <= 1'b0;
    end else begin
      dack_q <= dack_n;
      if (mode_we) single_q <= mode_bit;
      rd_stb <= ack_edge & rd_ok;
      wr_stb <= ack_edge & wr_ok;
      if (!live) begin
        drq_q  <= 1'b0;
        done_q <= 1'b0;
      end else if (done_q) begin
        drq_q <= 1'b0;
      end else if (ack_edge & last_xfer) begin
        drq_q  <= 1'b0;
        done_q <= 1'b1;
      end else if (single_q) begin
        drq_q <= ~ack_edge & (drq_q | dack_n);
      end else begin
        drq_q <= 1'b1;
      end
    end
  end

  assign drq = drq_q & live;

endmodule

module fdc_dma_req_chk (
  input logic clk,
  input logic rst_n,
  input logic mode_we,
  input logic dma_en,
  input logic xfer_pend,
  input logic dack_n,
  input logic last_xfer,
  input logic single_q,
  input logic drq,
  input logic rd_stb,
  input logic wr_stb
);

  // R3
  single_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dack_n) && dma_en && xfer_pend && single_q && !mode_we) |=> !drq);

  // R4
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drq && !single_q && !mode_we && !($fell(dack_n) && last_xfer))
      |=> (drq || !(dma_en && xfer_pend)));

  // R5
  last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dack_n) && last_xfer && dma_en && xfer_pend) |=> !drq);

  // R6
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> !rd_stb);

  // R6
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  // R6
  no_stray_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb || wr_stb) |-> ($past(dma_en) && $past(xfer_pend) && !$past(dack_n)));

endmodule

bind fdc_dma_req fdc_dma_req_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .dma_en(dma_en),
  .xfer_pend(xfer_pend), .dack_n(dack_n), .last_xfer(last_xfer),
  .single_q(single_q), .drq(drq), .rd_stb(rd_stb), .wr_stb(wr_stb)
);

// File: tb/fdc_dma_req_tb.sv
module fdc_dma_req_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_we = 1'b0, mode_bit = 1'b1;
  logic dma_en = 1'b0, xfer_pend = 1'b0, xfer_rd = 1'b0, fifo_en = 1'b0;
  logic dack_n = 1'b1, last_xfer = 1'b0, vfy_cyc = 1'b0;
  logic drq, rd_stb, wr_stb;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  fdc_dma_req u_dut (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_bit(mode_bit),
    .dma_en(dma_en), .xfer_pend(xfer_pend), .xfer_rd(xfer_rd), .fifo_en(fifo_en),
    .dack_n(dack_n), .last_xfer(last_xfer), .vfy_cyc(vfy_cyc),
    .drq(drq), .rd_stb(rd_stb), .wr_stb(wr_stb)
  );

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    chk(drq, 1'b0, "R1 drq after reset");
    chk(rd_stb, 1'b0, "R1 rd_stb after reset");
    chk(wr_stb, 1'b0, "R1 wr_stb after reset");

    // R1: default mode is single: request drops after an acknowledge
    dma_en = 1'b1; xfer_pend = 1'b1; xfer_rd = 1'b1;
    step();
    chk(drq, 1'b1, "R1 drq rises with default mode");
    dack_n = 1'b0;
    step();
    chk(drq, 1'b0, "R1 default mode drops drq after ack");
    dack_n = 1'b1; xfer_pend = 1'b0;
    step();

    // R2: no request while DMA is disabled; acks outside a transfer give no strobe (R6)
    dma_en = 1'b0; xfer_pend = 1'b1;
    step();
    chk(drq, 1'b0, "R2 drq with dma_en low");
    dack_n = 1'b0;
    step();
    chk(rd_stb, 1'b0, "R6 no rd_stb outside transfer");
    chk(wr_stb, 1'b0, "R6 no wr_stb outside transfer");
    dack_n = 1'b1;
    step();

    // R2: immediate drop when dma_en falls while requesting
    dma_en = 1'b1;
    step();
    chk(drq, 1'b1, "R3 drq up before R2 test");
    dma_en = 1'b0;
    #1;
    chk(drq, 1'b0, "R2 drq drops same cycle as dma_en");
    xfer_pend = 1'b0;
    step();

    for (int c = 0; c < 32; c++) begin
      logic burst, rd, vf, fe, tc, exp_rd, exp_wr;
      burst = c[0]; rd = c[1]; vf = c[2]; fe = c[3]; tc = c[4];
      exp_rd = rd & (~vf | ~fe);
      exp_wr = ~rd & ~vf;

      // R8: load mode bit
      mode_we = 1'b1; mode_bit = ~burst;
      step();
      mode_we = 1'b0;
      dma_en = 1'b1; xfer_pend = 1'b1; xfer_rd = rd; fifo_en = fe; vfy_cyc = vf;
      step();
      chk(drq, 1'b1, $sformatf("R3 drq rise case %0d", c));
      dack_n = 1'b0; last_xfer = tc;
      step();
      chk(drq, burst & ~tc, $sformatf("R4/R5 drq after ack case %0d", c));
      chk(rd_stb, exp_rd, $sformatf("R6/R7 rd_stb case %0d", c));
      chk(wr_stb, exp_wr, $sformatf("R6/R7 wr_stb case %0d", c));
      last_xfer = 1'b0;
      step();
      chk(drq, burst & ~tc, $sformatf("R3/R4 drq during ack case %0d", c));
      chk(rd_stb | wr_stb, 1'b0, $sformatf("R6 single pulse case %0d", c));
      dack_n = 1'b1;
      step();
      chk(drq, ~tc, $sformatf("R3/R5 drq after release case %0d", c));
      step();
      chk(drq, ~tc, $sformatf("R5 drq held case %0d", c));
      xfer_pend = 1'b0;
      #1;
      chk(drq, 1'b0, $sformatf("R2 drq with pend low case %0d", c));
      step();
      vfy_cyc = 1'b0;
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule